// File: doc/BRIEF.md
# State-Enable Access Permission Checker

This block decides, in one combinational pass, whether an access to a guarded architectural resource is allowed. It receives the current privilege level, whether execution is virtualized, whether the state-enable feature is built in and whether supervisor mode exists. It also receives the full set of machine, hypervisor and supervisor enable registers, each with `NUM_IDX` entries. A register index and a bit position select one enable bit from each of the three levels. Those three bits are then checked in a fixed order. The block returns a two-bit code: no exception, illegal instruction, or virtual instruction fault. Storing the enable registers and taking the trap are left to the surrounding core.

The block also guards the environment-configuration registers, which are the supervisor one, the hypervisor one and the hypervisor upper half. When the core asserts the read or write request for one of them, the block ignores the index and bit inputs. It checks the environment-config enable bit of entry 0 instead. It forwards the request strobe, and the read data, only when that check allows the access.

Top module: `stateen_gate`

## Requirements
- R1: When `priv_i` is machine (2'b11), or `feat_i` is 0, `result_o` is 2'b00 (no exception). Codes are 2'b00 none, 2'b01 illegal instruction, 2'b10 virtual instruction fault. Privilege codes are 2'b11 machine, 2'b01 supervisor and 2'b00 user; 2'b10 is treated like supervisor.
- R2: Outside machine level with the feature present, a clear machine-level enable bit gives 2'b01. This check overrides every other one.
- R3: With the machine bit set and `virt_i` high, a clear hypervisor-level bit gives 2'b10.
- R4: With `virt_i` high at user level and the machine and hypervisor bits set, a clear supervisor-level bit gives 2'b10. At virtualized supervisor level the supervisor bit has no effect.
- R5: With `virt_i` low at user level, `smode_i` high and the machine bit set, a clear supervisor-level bit gives 2'b01. Outside virtualization the hypervisor bit has no effect. With `smode_i` low the supervisor bit has no effect.
- R6: While `env_rd_i` or `env_wr_i` is high, the check uses entry 0, bit `ENV_BIT` (62 by default), and `idx_i` and `bit_i` have no effect.
- R7: `env_wr_o` and `env_rd_o` follow their request inputs only when `result_o` is 2'b00, and are 0 otherwise. `env_rdata_o` equals `env_rdata_i` when the access is allowed and is all zeros otherwise.
- R8: With `feat_i` low, `result_o` does not depend on any enable register value.
- R9: Only bit `bit_i` of entry `idx_i` of each level is examined. Every other bit and entry has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Virtualization mode active |
| feat_i | input | 1 | State-enable feature implemented |
| smode_i | input | 1 | Supervisor mode implemented |
| idx_i | input | IDXW (2) | Enable register entry to check |
| bit_i | input | BITW (6) | Enable bit position to check |
| men_i | input | NUM_IDX x XLEN | Machine-level enable registers |
| hen_i | input | NUM_IDX x XLEN | Hypervisor-level enable registers |
| sen_i | input | NUM_IDX x XLEN | Supervisor-level enable registers |
| env_rd_i | input | 1 | Read request to an environment-config register |
| env_wr_i | input | 1 | Write request to an environment-config register |
| env_rdata_i | input | XLEN | Read data from the environment-config register |
| result_o | output | 2 | Access result code |
| env_rd_o | output | 1 | Gated read strobe |
| env_wr_o | output | 1 | Gated write strobe |
| env_rdata_o | output | XLEN | Gated read data |

## Verification
The block holds no state, so a fault in its selection or priority logic shows on `result_o` in the same evaluation as the stimulus that reaches it. A wrong bit or entry selection shows only when the selected bit differs from its neighbours. For that reason the stimulus sets every bit except the target to the opposite value. A wrong priority order shows only when two or more levels are clear at once, so several cases clear more than one level. A leaking environment-config write appears directly as a high `env_wr_o` alongside a nonzero result code.

// File: rtl/stateen_pkg.sv
package stateen_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_t;

    typedef enum logic [1:0] {
        RES_NONE    = 2'b00,
        RES_ILLEGAL = 2'b01,
        RES_VIRT    = 2'b10
    } res_t;

    localparam int unsigned DEF_XLEN    = 64;
    localparam int unsigned DEF_NUM_IDX = 4;
    localparam int unsigned DEF_ENV_BIT = 62;

endpackage

// File: rtl/stateen_bit_pick.sv
module stateen_bit_pick #(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned NUM_IDX = 4,
    parameter int unsigned ENV_BIT = 62,
    localparam int unsigned IDXW   = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1,
    localparam int unsigned BITW   = $clog2(XLEN)
) (
    input  logic                           env_acc_i,
    input  logic [IDXW-1:0]                idx_i,
    input  logic [BITW-1:0]                bit_i,
    input  logic [NUM_IDX-1:0][XLEN-1:0]   men_i,
    input  logic [NUM_IDX-1:0][XLEN-1:0]   hen_i,
    input  logic [NUM_IDX-1:0][XLEN-1:0]   sen_i,
    output logic                           m_o,
    output logic                           h_o,
    output logic                           s_o
);

    localparam logic [BITW-1:0] ENV_POS = BITW'(ENV_BIT);

    logic [IDXW-1:0]    eff_idx;
    logic [BITW-1:0]    eff_bit;
    logic [NUM_IDX-1:0] m_col;
    logic [NUM_IDX-1:0] h_col;
    logic [NUM_IDX-1:0] s_col;

    // Environment-config accesses always look at entry 0, fixed bit.
    assign eff_idx = env_acc_i ? '0 : idx_i;
    assign eff_bit = env_acc_i ? ENV_POS : bit_i;

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_col
        assign m_col[g] = men_i[g][eff_bit];
        assign h_col[g] = hen_i[g][eff_bit];
        assign s_col[g] = sen_i[g][eff_bit];
    end

    assign m_o = m_col[eff_idx];
    assign h_o = h_col[eff_idx];
    assign s_o = s_col[eff_idx];

endmodule

// File: rtl/stateen_decide.sv
module stateen_decide
    import stateen_pkg::*;
(
    input  logic [1:0] priv_i,
    input  logic       virt_i,
    input  logic       feat_i,
    input  logic       smode_i,
    input  logic       m_i,
    input  logic       h_i,
    input  logic       s_i,
    output logic [1:0] res_o
);

    logic is_m;
    logic is_u;

    assign is_m = (priv_i == PRIV_M);
    assign is_u = (priv_i == PRIV_U);

    // Fixed priority: bypass, machine level, hypervisor level, supervisor level.
    always_comb begin
        res_o = RES_NONE;
        if (is_m || !feat_i) begin
            res_o = RES_NONE;
        end else if (!m_i) begin
            res_o = RES_ILLEGAL;
        end else if (virt_i && !h_i) begin
            res_o = RES_VIRT;
        end else if (virt_i && is_u && !s_i) begin
            res_o = RES_VIRT;
        end else if (!virt_i && is_u && smode_i && !s_i) begin
            res_o = RES_ILLEGAL;
        end
    end

endmodule

// File: rtl/stateen_env_gate.sv
module stateen_env_gate
    import stateen_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [1:0]      res_i,
    input  logic            rd_i,
    input  logic            wr_i,
    input  logic [XLEN-1:0] rdata_i,
    output logic            rd_o,
    output logic            wr_o,
    output logic [XLEN-1:0] rdata_o
);

    logic allow;

    assign allow   = (res_i == RES_NONE);
    assign rd_o    = rd_i & allow;
    assign wr_o    = wr_i & allow;
    assign rdata_o = (allow && rd_i) ? rdata_i : '0;

endmodule

// File: rtl/stateen_gate.sv
module stateen_gate #(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned NUM_IDX = 4,
    parameter int unsigned ENV_BIT = 62,
    localparam int unsigned IDXW   = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1,
    localparam int unsigned BITW   = $clog2(XLEN)
) (
    input  logic [1:0]                   priv_i,
    input  logic                         virt_i,
    input  logic                         feat_i,
    input  logic                         smode_i,
    input  logic [IDXW-1:0]              idx_i,
    input  logic [BITW-1:0]              bit_i,
    input  logic [NUM_IDX-1:0][XLEN-1:0] men_i,
    input  logic [NUM_IDX-1:0][XLEN-1:0] hen_i,
    input  logic [NUM_IDX-1:0][XLEN-1:0] sen_i,
    input  logic                         env_rd_i,
    input  logic                         env_wr_i,
    input  logic [XLEN-1:0]              env_rdata_i,
    output logic [1:0]                   result_o,
    output logic                         env_rd_o,
    output logic                         env_wr_o,
    output logic [XLEN-1:0]              env_rdata_o
);

    logic env_acc;
    logic m_bit;
    logic h_bit;
    logic s_bit;

    assign env_acc = env_rd_i | env_wr_i;

    stateen_bit_pick #(
        .XLEN    (XLEN),
        .NUM_IDX (NUM_IDX),
        .ENV_BIT (ENV_BIT)
    ) u_pick (
        .env_acc_i (env_acc),
        .idx_i     (idx_i),
        .bit_i     (bit_i),
        .men_i     (men_i),
        .hen_i     (hen_i),
        .sen_i     (sen_i),
        .m_o       (m_bit),
        .h_o       (h_bit),
        .s_o       (s_bit)
    );

    stateen_decide u_decide (
        .priv_i  (priv_i),
        .virt_i  (virt_i),
        .feat_i  (feat_i),
        .smode_i (smode_i),
        .m_i     (m_bit),
        .h_i     (h_bit),
        .s_i     (s_bit),
        .res_o   (result_o)
    );

    stateen_env_gate #(
        .XLEN (XLEN)
    ) u_env (
        .res_i   (result_o),
        .rd_i    (env_rd_i),
        .wr_i    (env_wr_i),
        .rdata_i (env_rdata_i),
        .rd_o    (env_rd_o),
        .wr_o    (env_wr_o),
        .rdata_o (env_rdata_o)
    );

endmodule

// File: rtl/stateen_gate_chk.sv
module stateen_gate_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic [1:0]      priv_i,
    input logic            virt_i,
    input logic            feat_i,
    input logic            smode_i,
    input logic            m_bit,
    input logic            h_bit,
    input logic            s_bit,
    input logic            env_rd_i,
    input logic            env_wr_i,
    input logic [1:0]      result_o,
    input logic            env_rd_o,
    input logic            env_wr_o,
    input logic [XLEN-1:0] env_rdata_o
);

    logic active;
    assign active = feat_i && (priv_i != 2'b11);

    always_comb begin
        a_code_legal: assert (result_o != 2'b11)
            else $error("result code 2'b11 produced");
        if (!active) begin
            a_r1_bypass: assert (result_o == 2'b00)
                else $error("R1 bypass violated");
        end
        if (active && !m_bit) begin
            a_r2_machine_first: assert (result_o == 2'b01)
                else $error("R2 machine level priority violated");
        end
        if (active && m_bit && virt_i && !h_bit) begin
            a_r3_hyp_virt: assert (result_o == 2'b10)
                else $error("R3 hypervisor level violated");
        end
        if (active && m_bit && h_bit && virt_i && priv_i == 2'b00 && !s_bit) begin
            a_r4_sup_virt: assert (result_o == 2'b10)
                else $error("R4 virtual user level violated");
        end
        if (active && m_bit && !virt_i && priv_i == 2'b00 && smode_i && !s_bit) begin
            a_r5_sup_native: assert (result_o == 2'b01)
                else $error("R5 native user level violated");
        end
        if (env_wr_o) begin
            a_r7_write_gate: assert (env_wr_i && result_o == 2'b00)
                else $error("R7 write strobe leaked");
        end
        if (env_rd_o) begin
            a_r7_read_gate: assert (env_rd_i && result_o == 2'b00)
                else $error("R7 read strobe leaked");
        end
        if (result_o != 2'b00) begin
            a_r7_rdata_zero: assert (env_rdata_o == '0)
                else $error("R7 read data leaked");
        end
    end

endmodule

bind stateen_gate stateen_gate_chk #(.XLEN(XLEN)) u_chk (
    .priv_i      (priv_i),
    .virt_i      (virt_i),
    .feat_i      (feat_i),
    .smode_i     (smode_i),
    .m_bit       (m_bit),
    .h_bit       (h_bit),
    .s_bit       (s_bit),
    .env_rd_i    (env_rd_i),
    .env_wr_i    (env_wr_i),
    .result_o    (result_o),
    .env_rd_o    (env_rd_o),
    .env_wr_o    (env_wr_o),
    .env_rdata_o (env_rdata_o)
);

// File: tb/stateen_gate_test.sv
module stateen_gate_test;

    localparam int XL  = 64;
    localparam int NI  = 4;
    localparam int NV  = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [1:0]           priv;
    logic                 virt, feat, smode;
    logic [1:0]           idx;
    logic [5:0]           bsel;
    logic [NI-1:0][XL-1:0] men, hen, sen;
    logic                 env_rd, env_wr;
    logic [XL-1:0]        env_rdata;
    logic [1:0]           result;
    logic                 env_rd_q, env_wr_q;
    logic [XL-1:0]        env_rdata_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    stateen_gate uut (
        .priv_i      (priv),
        .virt_i      (virt),
        .feat_i      (feat),
        .smode_i     (smode),
        .idx_i       (idx),
        .bit_i       (bsel),
        .men_i       (men),
        .hen_i       (hen),
        .sen_i       (sen),
        .env_rd_i    (env_rd),
        .env_wr_i    (env_wr),
        .env_rdata_i (env_rdata),
        .result_o    (result),
        .env_rd_o    (env_rd_q),
        .env_wr_o    (env_wr_q),
        .env_rdata_o (env_rdata_q)
    );

    // {req[3:0], priv[1:0], virt, feat, smode, m, h, s, exp[1:0]}
    localparam logic [13:0] TBL [NV] = '{
        {4'd1, 2'b11, 1'b0, 1'b1, 1'b1, 3'b000, 2'b00},  // R1 machine bypass
        {4'd1, 2'b01, 1'b0, 1'b0, 1'b1, 3'b000, 2'b00},  // R1 feature absent
        {4'd8, 2'b00, 1'b1, 1'b0, 1'b1, 3'b000, 2'b00},  // R8 absent, virt user
        {4'd2, 2'b01, 1'b0, 1'b1, 1'b1, 3'b011, 2'b01},  // R2 machine clear
        {4'd2, 2'b00, 1'b1, 1'b1, 1'b1, 3'b000, 2'b01},  // R2 beats virt faults
        {4'd3, 2'b01, 1'b1, 1'b1, 1'b1, 3'b101, 2'b10},  // R3 hyp clear
        {4'd4, 2'b01, 1'b1, 1'b1, 1'b1, 3'b110, 2'b00},  // R4 sup ignored at VS
        {4'd4, 2'b00, 1'b1, 1'b1, 1'b1, 3'b110, 2'b10},  // R4 sup clear at VU
        {4'd3, 2'b00, 1'b1, 1'b1, 1'b1, 3'b100, 2'b10},  // R3 at VU
        {4'd5, 2'b00, 1'b0, 1'b1, 1'b1, 3'b100, 2'b01},  // R5 hyp ignored native
        {4'd5, 2'b00, 1'b0, 1'b1, 1'b0, 3'b110, 2'b00},  // R5 no supervisor mode
        {4'd5, 2'b01, 1'b0, 1'b1, 1'b1, 3'b100, 2'b00},  // R5 native supervisor
        {4'd5, 2'b00, 1'b0, 1'b1, 1'b1, 3'b111, 2'b00},  // R5 all set native
        {4'd4, 2'b00, 1'b1, 1'b1, 1'b1, 3'b111, 2'b00},  // R4 all set virt
        {4'd1, 2'b11, 1'b1, 1'b1, 1'b1, 3'b000, 2'b00},  // R1 machine with virt
        {4'd2, 2'b01, 1'b1, 1'b1, 1'b1, 3'b011, 2'b01}   // R2 under virt
    };

    task automatic chk(input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        priv = 2'b01; virt = 1'b0; feat = 1'b1; smode = 1'b1;
        idx = '0; bsel = '0; env_rd = 1'b0; env_wr = 1'b0;
        env_rdata = 64'hA5A5_5A5A_0F0F_F0F0;
        men = '0; hen = '0; sen = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        feat = 1'b0;
        @(negedge clk);
        // R7: no request, nothing forwarded
        chk("R7 idle result", 64'(result), 64'd0);
        chk("R7 idle strobes", 64'({env_rd_q, env_wr_q}), 64'd0);
        chk("R7 idle rdata", env_rdata_q, 64'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [13:0] e;
            int ti, tb;
            e  = TBL[i];
            ti = i % NI;
            tb = (i * 13 + 5) % XL;
            @(posedge clk); #1;
            idle();
            priv = e[9:8]; virt = e[7]; feat = e[6]; smode = e[5];
            idx = 2'(ti); bsel = 6'(tb);
            men = '1; hen = '1; sen = '1;
            if (!e[4]) men[ti][tb] = 1'b0;
            if (!e[3]) hen[ti][tb] = 1'b0;
            if (!e[2]) sen[ti][tb] = 1'b0;
            @(negedge clk);
            chk($sformatf("R%0d table %0d", e[13:10], i), 64'(result), 64'(e[1:0]));
        end

        // R9: only the selected bit matters (target set, rest clear)
        @(posedge clk); #1;
        idle();
        priv = 2'b00; virt = 1'b1; idx = 2'd2; bsel = 6'd17;
        men[2][17] = 1'b1; hen[2][17] = 1'b1; sen[2][17] = 1'b1;
        @(negedge clk);
        chk("R9 isolated set bit", 64'(result), 64'd0);
        @(posedge clk); #1;
        men[2][17] = 1'b0; men[1][17] = 1'b1; men[2][16] = 1'b1; men[2][18] = 1'b1; men[3] = '1;
        @(negedge clk);
        chk("R9 neighbours set target clear", 64'(result), 64'd1);

        // R8: feature absent, patterns on enables
        for (int p = 0; p < 3; p++) begin
            @(posedge clk); #1;
            idle();
            feat = 1'b0; priv = 2'b00; virt = 1'b1; idx = 2'(p); bsel = 6'(p * 9);
            men = (p == 0) ? '0 : (p == 1) ? '1 : {NI*XL/2{2'b10}};
            hen = men; sen = ~men;
            @(negedge clk);
            chk($sformatf("R8 pattern %0d", p), 64'(result), 64'd0);
        end

        // R6/R7: env write, entry 0 bit 62 clear, idx/bit point at set bit
        @(posedge clk); #1;
        idle();
        env_wr = 1'b1; idx = 2'd3; bsel = 6'd5;
        men = '1; hen = '1; sen = '1; men[0][62] = 1'b0;
        @(negedge clk);
        chk("R6 env check uses entry 0 bit 62", 64'(result), 64'd1);
        chk("R7 write suppressed", 64'(env_wr_q), 64'd0);

        // R6/R7: env write allowed, idx/bit point at clear bit
        @(posedge clk); #1;
        idle();
        env_wr = 1'b1; idx = 2'd3; bsel = 6'd5;
        men[0][62] = 1'b1;
        @(negedge clk);
        chk("R6 env allowed ignores idx/bit", 64'(result), 64'd0);
        chk("R7 write forwarded", 64'(env_wr_q), 64'd1);

        // R3/R7: env read under virt, hyp bit clear
        @(posedge clk); #1;
        idle();
        env_rd = 1'b1; virt = 1'b1;
        men[0][62] = 1'b1; sen[0][62] = 1'b1;
        @(negedge clk);
        chk("R3 env read virt fault", 64'(result), 64'd2);
        chk("R7 read strobe suppressed", 64'(env_rd_q), 64'd0);
        chk("R7 read data zeroed", env_rdata_q, 64'd0);

        // R5/R7: env read native user, all set
        @(posedge clk); #1;
        idle();
        env_rd = 1'b1; priv = 2'b00;
        men[0][62] = 1'b1; sen[0][62] = 1'b1;
        @(negedge clk);
        chk("R5 env read user ok", 64'(result), 64'd0);
        chk("R7 read strobe forwarded", 64'(env_rd_q), 64'd1);
        chk("R7 read data passed", env_rdata_q, 64'hA5A5_5A5A_0F0F_F0F0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule